// File: doc/BRIEF.md
# Interrupt Cause and Mask Controller

This block gathers interrupt causes raised by the events inside a network interface and decides when a single interrupt line toward the processor goes high. Events post cause bits, and the bits stay set until host software clears them. A mask register chooses which causes may raise the line. An auto-mask register names mask bits that are removed by themselves when the host touches the cause register. A throttle interval register sets how soon the line may be raised again after it has dropped.

The host reaches the four registers through a plain 32-bit port. Each access is a one-cycle read or write strobe with a 2-bit register select: 0 is cause, 1 is mask, 2 is auto-mask and 3 is throttle interval. Read data is combinational and shows the state before the clock edge that applies the access. The block checks the masked cause state again in every cycle. It raises the line at once, starts an interval timer, or drops the line and cancels the timer. The timer counts in ticks of `TICK_CYCLES` clocks, and one tick stands for 256 ns.

Top module: `intr_cause_unit`

## Requirements
- R1: After reset the cause, mask, auto-mask and interval registers read zero and `irq` is low.
- R2: A cause read returns {line flag in bit 31, causes in bits 30:0}. Bits 30:0 are cleared by that read only if the line flag is set or the mask is zero. Otherwise they keep their value.
- R3: A cause read while the line flag is set and `am_en` is high removes the auto-mask bits from the mask.
- R4: A cause write clears each bit 30:0 that is written as one, and bit 31 of the written value has no effect. With `am_en` high, the write also removes the auto-mask bits from the mask. With `am_en` low the mask is left unchanged.
- R5: Posted bits are ORed into causes 30:0. Posting a bit that is already pending changes nothing. A bit posted in the same cycle as a clearing read or write stays set.
- R6: With interval zero, `irq` is high in the cycle after any cause is active under the mask.
- R7: With a nonzero interval and no masked cause active before, `irq` rises exactly interval×`TICK_CYCLES` cycles after the edge on which a masked cause became active. A timer that is already running is not restarted, and `irq` stays low while it runs.
- R8: A post with `post_now` high that makes a masked cause active while none was active raises `irq` on the next edge, whatever the interval.
- R9: When no masked cause remains, `irq` drops on that edge and the timer is cancelled. A later masked cause starts a full new interval.
- R10: `irq` is high only while some cause is active under the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_rd | input | 1 | Register read strobe, one cycle (ignored when reg_wr is high) |
| reg_addr | input | 2 | Register select: 0 cause, 1 mask, 2 auto-mask, 3 interval |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| post_cause | input | 31 | Cause bits posted by internal events this cycle |
| post_now | input | 1 | Marks the post as immediate, bypassing the timer |
| am_en | input | 1 | Auto-mask enable |
| irq | output | 1 | Interrupt line toward the processor |

## Verification
Two functions can meet in one cycle: a host access that clears causes, and an event post into the same register. The bench drives a clearing read, and then a write-one-to-clear, on the same clock edge as a post. It then reads the register back to confirm that the posted bit survived and the old bits were cleared. A timer expiry can also coincide with a masked cause being withdrawn. The bench cancels a running interval partway through, re-arms it, and measures the rise against a full fresh interval instead of the original one.

// File: rtl/intr_pkg.sv
package intr_pkg;

    localparam int DATA_W  = 32;
    localparam int CAUSE_W = 31;

    typedef enum logic [1:0] {
        SEL_CAUSE = 2'd0,
        SEL_MASK  = 2'd1,
        SEL_AUTO  = 2'd2,
        SEL_ITV   = 2'd3
    } reg_sel_e;

    typedef logic [CAUSE_W-1:0] cause_t;

    // Decision of the line controller for one cycle
    typedef struct packed {
        logic start;
        logic cancel;
        logic line;
    } line_dec_t;

    function automatic logic [DATA_W-1:0] pack_cause(input logic line, input cause_t c);
        return {line, c};
    endfunction

endpackage

// File: rtl/intr_reg_file.sv
module intr_reg_file
    import intr_pkg::*;
#(
    parameter int ITV_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              rd,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  cause_t            post,
    input  logic              am_en,
    input  logic              line_q,
    output cause_t            cause_q,
    output cause_t            mask_q,
    output cause_t            auto_q,
    output logic [ITV_W-1:0]  itv_q,
    output cause_t            cause_d,
    output cause_t            mask_d,
    output logic [DATA_W-1:0] rdata
);
    cause_t           auto_d;
    logic [ITV_W-1:0] itv_d;
    logic             unused_wbits;

    assign unused_wbits = ^wdata[DATA_W-1:ITV_W];

    always_comb begin
        cause_d = cause_q;
        mask_d  = mask_q;
        auto_d  = auto_q;
        itv_d   = itv_q;
        if (wr) begin
            unique case (reg_sel_e'(addr))
                SEL_CAUSE: begin
                    cause_d = cause_q & ~wdata[CAUSE_W-1:0];
                    if (am_en) mask_d = mask_q & ~auto_q;
                end
                SEL_MASK:  mask_d = wdata[CAUSE_W-1:0];
                SEL_AUTO:  auto_d = wdata[CAUSE_W-1:0];
                SEL_ITV:   itv_d  = wdata[ITV_W-1:0];
                default: ;
            endcase
        end else if (rd && reg_sel_e'(addr) == SEL_CAUSE) begin
            if (line_q || mask_q == '0) cause_d = '0;
            if (am_en && line_q)        mask_d  = mask_q & ~auto_q;
        end
        cause_d = cause_d | post;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= '0;
            mask_q  <= '0;
            auto_q  <= '0;
            itv_q   <= '0;
        end else begin
            cause_q <= cause_d;
            mask_q  <= mask_d;
            auto_q  <= auto_d;
            itv_q   <= itv_d;
        end
    end

    always_comb begin
        unique case (reg_sel_e'(addr))
            SEL_CAUSE: rdata = pack_cause(line_q, cause_q);
            SEL_MASK:  rdata = {1'b0, mask_q};
            SEL_AUTO:  rdata = {1'b0, auto_q};
            SEL_ITV:   rdata = {{(DATA_W-ITV_W){1'b0}}, itv_q};
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/intr_throttle.sv
module intr_throttle #(
    parameter int TICK_CYCLES = 64,
    parameter int ITV_W       = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             cancel,
    input  logic [ITV_W-1:0] interval,
    output logic             running,
    output logic             expire
);
    localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(TICK_CYCLES - 1);

    logic [PW-1:0]    pre_q;
    logic [ITV_W-1:0] ticks_q;
    logic             tick_roll;

    assign tick_roll = (pre_q == PRE_LAST);
    assign expire    = running && tick_roll &&
                       ({1'b0, ticks_q} + (ITV_W+1)'(1) >= {1'b0, interval});

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            pre_q   <= '0;
            ticks_q <= '0;
        end else if (cancel || expire) begin
            running <= 1'b0;
            pre_q   <= '0;
            ticks_q <= '0;
        end else if (start && !running) begin
            running <= 1'b1;
            pre_q   <= '0;
            ticks_q <= '0;
        end else if (running) begin
            if (tick_roll) begin
                pre_q   <= '0;
                ticks_q <= ticks_q + ITV_W'(1);
            end else begin
                pre_q   <= pre_q + PW'(1);
            end
        end
    end
endmodule

// File: rtl/intr_line_ctl.sv
module intr_line_ctl
    import intr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic act_next,
    input  logic act_prev,
    input  logic fresh,
    input  logic post_now,
    input  logic itv_zero,
    input  logic expire,
    input  logic running,
    output logic start,
    output logic cancel,
    output logic line_q
);
    line_dec_t dec;

    always_comb begin
        dec = '{start: 1'b0, cancel: 1'b0, line: line_q};
        if (!act_next) begin
            dec.cancel = 1'b1;
            dec.line   = 1'b0;
        end else if (itv_zero || (post_now && fresh && !act_prev)) begin
            dec.cancel = 1'b1;
            dec.line   = 1'b1;
        end else if (expire) begin
            dec.line   = 1'b1;
        end else begin
            dec.start  = !running && !line_q;
        end
    end

    assign start  = dec.start;
    assign cancel = dec.cancel;

    always_ff @(posedge clk) begin
        if (rst) line_q <= 1'b0;
        else     line_q <= dec.line;
    end
endmodule

// File: rtl/intr_cause_unit.sv
module intr_cause_unit
    import intr_pkg::*;
#(
    parameter int TICK_CYCLES = 64,
    parameter int ITV_W       = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [30:0] post_cause,
    input  logic        post_now,
    input  logic        am_en,
    output logic        irq
);
    cause_t           cause_q, mask_q, auto_q, cause_d, mask_d;
    logic [ITV_W-1:0] itv_q;
    logic             line_q, running, expire, start, cancel;
    logic             act_next, act_prev, fresh;

    intr_reg_file #(.ITV_W(ITV_W)) u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
        .wdata(reg_wdata), .post(post_cause), .am_en(am_en), .line_q(line_q),
        .cause_q(cause_q), .mask_q(mask_q), .auto_q(auto_q), .itv_q(itv_q),
        .cause_d(cause_d), .mask_d(mask_d), .rdata(reg_rdata)
    );

    assign act_next = |(cause_d & mask_d);
    assign act_prev = |(cause_q & mask_q);
    assign fresh    = |(post_cause & ~cause_q);

    intr_throttle #(.TICK_CYCLES(TICK_CYCLES), .ITV_W(ITV_W)) u_timer (
        .clk(clk), .rst(rst), .start(start), .cancel(cancel),
        .interval(itv_q), .running(running), .expire(expire)
    );

    intr_line_ctl u_line (
        .clk(clk), .rst(rst), .act_next(act_next), .act_prev(act_prev),
        .fresh(fresh), .post_now(post_now), .itv_zero(itv_q == '0),
        .expire(expire), .running(running), .start(start), .cancel(cancel),
        .line_q(line_q)
    );

    assign irq = line_q;
endmodule

// File: rtl/intr_cause_chk.sv
module intr_cause_chk #(
    parameter int ITV_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             irq,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [1:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic [30:0]      post_cause,
    input logic             am_en,
    input logic [30:0]      cause_q,
    input logic [30:0]      mask_q,
    input logic [30:0]      auto_q,
    input logic [ITV_W-1:0] itv_q,
    input logic             running
);
    a_r10_line_needs_cause: assert property (@(posedge clk) disable iff (rst)
        irq |-> (|(cause_q & mask_q)));

    a_r6_zero_interval_raises: assert property (@(posedge clk) disable iff (rst)
        ((|(cause_q & mask_q)) && itv_q == '0 && $past(itv_q) == '0) |-> irq);

    a_r7_quiet_while_timing: assert property (@(posedge clk) disable iff (rst)
        running |-> !irq);

    a_r2_read_clears: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && !reg_wr && reg_addr == 2'd0 && irq) |=>
        ((cause_q & ~$past(post_cause)) == '0));

    a_r4_w1c: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd0) |=>
        ((cause_q & $past(reg_wdata[30:0]) & ~$past(post_cause)) == '0));

    a_r4_automask_write: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd0 && am_en) |=> ((mask_q & $past(auto_q)) == '0));

    a_r5_causes_sticky: assert property (@(posedge clk) disable iff (rst)
        (!reg_wr && !(reg_rd && reg_addr == 2'd0)) |=> (($past(cause_q) & ~cause_q) == '0));
endmodule

bind intr_cause_unit intr_cause_chk #(.ITV_W(ITV_W)) u_chk (
    .clk(clk), .rst(rst), .irq(irq), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .post_cause(post_cause),
    .am_en(am_en), .cause_q(cause_q), .mask_q(mask_q), .auto_q(auto_q),
    .itv_q(itv_q), .running(running)
);

// File: tb/tb_intr_cause_unit.sv
`timescale 1ns/1ps
module tb_intr_cause_unit;
    localparam int TICK = 64;   // 64 x 4 ns = 256 ns per tick

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0, post_now = 1'b0, am_en = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [30:0] post_cause = '0;
    logic        irq;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    intr_cause_unit #(.TICK_CYCLES(TICK), .ITV_W(16)) dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .post_cause(post_cause), .post_now(post_now), .am_en(am_en), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One access cycle; starts and ends at a falling edge
    task automatic acc(input logic wr, input logic rd, input logic [1:0] a,
                       input logic [31:0] d, input logic [30:0] p, input logic nw,
                       output logic [31:0] rv);
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
        post_cause = p; post_now = nw;
        #1 rv = reg_rdata;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0; post_cause = '0; post_now = 1'b0;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        logic [31:0] x;
        acc(1'b1, 1'b0, a, d, '0, 1'b0, x);
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] v);
        acc(1'b0, 1'b1, a, '0, '0, 1'b0, v);
    endtask

    task automatic post(input logic [30:0] p, input logic nw);
        logic [31:0] x;
        acc(1'b0, 1'b0, 2'd0, '0, p, nw, x);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_rise(output int n);
        n = 0;
        while (!irq && n < 3000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        logic [31:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", {31'b0, irq}, 32'h0);
        rd_reg(2'd0, v); chk("R1 cause", v, 32'h0);
        rd_reg(2'd1, v); chk("R1 mask", v, 32'h0);
        rd_reg(2'd2, v); chk("R1 automask", v, 32'h0);
        rd_reg(2'd3, v); chk("R1 interval", v, 32'h0);

        // R2 mask zero: read clears
        post(31'h5, 1'b0);
        rd_reg(2'd0, v); chk("R2 read value", v, 32'h5);
        rd_reg(2'd0, v); chk("R2 cleared with zero mask", v, 32'h0);

        // R5 repost / R2 no clear with line low and mask set
        wr_reg(2'd1, 32'h10);
        post(31'h2, 1'b0);
        post(31'h2, 1'b0);
        chk("R5 repost irq", {31'b0, irq}, 32'h0);
        rd_reg(2'd0, v); chk("R5 repost value", v, 32'h2);
        rd_reg(2'd0, v); chk("R2 kept when line low", v, 32'h2);

        // R4 write-one-to-clear, bit 31 ignored
        wr_reg(2'd0, 32'h8000_0002);
        rd_reg(2'd0, v); chk("R4 w1c", v, 32'h0);

        // R6 zero interval raises next cycle
        post(31'h10, 1'b0);
        chk("R6 irq raised", {31'b0, irq}, 32'h1);
        rd_reg(2'd0, v); chk("R2 read with line", v, 32'h8000_0010);
        chk("R9 line dropped after clear", {31'b0, irq}, 32'h0);
        rd_reg(2'd0, v); chk("R2 cleared by read", v, 32'h0);

        // R5 post in same cycle as clearing read and as w1c
        post(31'h10, 1'b0);
        acc(1'b0, 1'b1, 2'd0, '0, 31'h4, 1'b0, v);
        chk("R5 read during post", v, 32'h8000_0010);
        chk("R5 irq after read", {31'b0, irq}, 32'h0);
        rd_reg(2'd0, v); chk("R5 post survives read", v, 32'h4);
        acc(1'b1, 1'b0, 2'd0, 32'h4, 31'h4, 1'b0, v);
        rd_reg(2'd0, v); chk("R5 post wins over w1c", v, 32'h4);
        wr_reg(2'd0, 32'h4);

        // R3 auto-mask on read
        am_en = 1'b1;
        wr_reg(2'd2, 32'h10);
        wr_reg(2'd1, 32'h30);
        post(31'h10, 1'b0);
        rd_reg(2'd0, v); chk("R3 read value", v, 32'h8000_0010);
        rd_reg(2'd1, v); chk("R3 mask reduced", v, 32'h20);
        wr_reg(2'd1, 32'h30);
        rd_reg(2'd0, v);
        rd_reg(2'd1, v); chk("R3 no automask when line low", v, 32'h30);

        // R4 auto-mask on write
        wr_reg(2'd0, 32'h0);
        rd_reg(2'd1, v); chk("R4 automask on write", v, 32'h20);
        am_en = 1'b0;
        wr_reg(2'd1, 32'h30);
        wr_reg(2'd0, 32'h0);
        rd_reg(2'd1, v); chk("R4 mask kept with am_en low", v, 32'h30);
        wr_reg(2'd2, 32'h0);

        // R7 throttle sweep over intervals
        wr_reg(2'd1, 32'h1);
        for (int itv = 1; itv <= 3; itv++) begin
            wr_reg(2'd3, itv);
            post(31'h1, 1'b0);
            wait_rise(n);
            chk($sformatf("R7 delay interval %0d", itv), n, itv * TICK);
            rd_reg(2'd0, v); chk("R7 cleared", v, 32'h8000_0001);
        end

        // R7 running timer not restarted by a new masked cause
        wr_reg(2'd1, 32'h3);
        wr_reg(2'd3, 32'd2);
        post(31'h1, 1'b0);
        idle(59);
        post(31'h2, 1'b0);
        wait_rise(n);
        chk("R7 not restarted", n + 60, 2 * TICK);
        rd_reg(2'd0, v); chk("R7 both causes", v, 32'h8000_0003);

        // R8 immediate post
        wr_reg(2'd3, 32'd3);
        post(31'h1, 1'b1);
        chk("R8 immediate", {31'b0, irq}, 32'h1);
        rd_reg(2'd0, v); chk("R8 cleared", v, 32'h8000_0001);

        // R9 cancel and fresh interval
        wr_reg(2'd1, 32'h1);
        wr_reg(2'd3, 32'd2);
        post(31'h1, 1'b0);
        idle(9);
        wr_reg(2'd1, 32'h0);
        idle(9);
        wr_reg(2'd1, 32'h1);
        wait_rise(n);
        chk("R9 full fresh interval", n, 2 * TICK);
        wr_reg(2'd1, 32'h0);
        chk("R9 drop when unmasked", {31'b0, irq}, 32'h0);
        rd_reg(2'd0, v); chk("R9 cause after drop", v, 32'h1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule